// File: doc/BRIEF.md
# Interlocked Three-Line Byte Handshake

This block carries bytes from one talker to a group of listeners over a shared 8-bit data bus. Three handshake lines pace the transfer. The talker drives the data and a data-valid strobe. Two other lines, "hold" and "pending", are active-low wired-AND lines that every enabled listener can pull low. The hold line stays low while any listener cannot take a new byte. The pending line stays low until every listener has latched the byte on the bus. Because each step waits for the step before it, the slowest listener sets the pace and no byte is lost, whatever the speed of each device.

On the local side, the talker takes bytes from a valid/ready stream. Each listener hands the bytes it receives to its own valid/ready sink through a one-byte holding register. A programmable settling count can add a delay between the moment the bus becomes ready and the assertion of data-valid. Listeners can be enabled or disabled while the bus is idle, so one bus instance can serve from one to fourteen active listeners.

Top module: `hs_bus_top`

## Requirements
- R1: While `rst_ni` is low, `bus_valid_n_o` is 1, `bus_hold_n_o` is 0, `bus_pend_n_o` is 0 and every `snk_valid_o` bit is 0.
- R2: The talker pulls `bus_valid_n_o` low only when `bus_hold_n_o` is 1 and `bus_pend_n_o` is 0 on that cycle.
- R3: When the talker is waiting with a byte and `bus_pend_n_o` is low, `bus_valid_n_o` falls exactly `settle_i + 1` cycles after `bus_hold_n_o` rises.
- R4: `bus_data_o` stays stable while `bus_valid_n_o` is low. `bus_valid_n_o` returns to 1 only on a cycle where `bus_pend_n_o` is 1.
- R5: Every enabled listener presents each byte on its sink in the order the talker received the bytes. It holds `snk_valid_o` and the data stable until `snk_ready_i` is 1.
- R6: The hold and pending lines read 1 only when every enabled listener releases them. A listener with its `lsn_en_i` bit at 0 receives no byte and cannot stall the bus, even when its sink is not ready.
- R7: A listener whose holding register is full keeps the hold line low. The next byte waits on the bus, and no other listener receives it until the full sink drains. No byte is lost.
- R8: The pending line rises only while the hold line is low and data-valid is low. After data-valid is released, the listeners pull the pending line low again.
- R9: `src_ready_o` is 1 only while the talker is idle. A byte is taken from the stream when `src_valid_i` and `src_ready_o` are both 1 at a clock edge, and no new byte is taken until the current one has finished on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset for the whole bus |
| settle_i | input | SETTLE_W | Extra cycles between the bus becoming ready and data-valid |
| src_data_i | input | DATA_W | Byte offered to the talker |
| src_valid_i | input | 1 | Talker stream valid |
| src_ready_o | output | 1 | Talker stream ready (talker idle) |
| lsn_en_i | input | N_LSN | Per-listener enable; change only while the bus is idle |
| snk_data_o | output | N_LSN*DATA_W | Received bytes, listener i in slice i |
| snk_valid_o | output | N_LSN | Per-listener sink valid |
| snk_ready_i | input | N_LSN | Per-listener sink ready |
| bus_data_o | output | DATA_W | Data bus as driven by the talker |
| bus_valid_n_o | output | 1 | Data-valid line, low = asserted |
| bus_hold_n_o | output | 1 | Wired not-ready line, low = some listener not ready |
| bus_pend_n_o | output | 1 | Wired not-accepted line, low = some listener has not accepted |

## Verification
The hardest case to reach is a second byte sitting on the bus while one listener's register is still full and the other listeners have already drained. The bench gets there by holding one listener's sink not-ready, pushing a byte that all listeners latch, and pushing a second byte that the talker accepts and then cannot put on the bus. From that stalled state it releases the sink on a known edge. It then counts the cycles from the rise of the hold line to data-valid, with a zero and a non-zero settling count. In the same way, it disables a listener whose sink is blocked and shows that the transfer still completes without that listener.

// File: rtl/hs_bus_pkg.sv
package hs_bus_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE,
    SRC_WAIT,
    SRC_SETTLE,
    SRC_VALID
  } src_state_e;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_WAIT,
    ACC_HOLD,
    ACC_DONE
  } acc_state_e;
endpackage

// File: rtl/hs_wired_line.sv
// Active-low wired line: reads 1 only when no driver pulls low.
module hs_wired_line #(
  parameter int unsigned N_DRV = 3
) (
  input  logic [N_DRV-1:0] drive_n_i,
  output logic             line_n_o
);
  assign line_n_o = &drive_n_i;
endmodule

// File: rtl/hs_source.sv
module hs_source
  import hs_bus_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SETTLE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [DATA_W-1:0]   src_data_i,
  input  logic                src_valid_i,
  output logic                src_ready_o,
  input  logic                hold_n_i,
  input  logic                pend_n_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                valid_n_o
);
  src_state_e          state_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic [DATA_W-1:0]   data_q;
  logic                bus_ready;

  // all listeners ready and none still holding a previous acceptance
  assign bus_ready = hold_n_i && !pend_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRC_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        SRC_IDLE: if (src_valid_i) begin
          data_q  <= src_data_i;
          state_q <= SRC_WAIT;
        end
        SRC_WAIT: if (bus_ready) begin
          if (settle_i == '0) begin
            state_q <= SRC_VALID;
          end else begin
            cnt_q   <= settle_i - SETTLE_W'(1);
            state_q <= SRC_SETTLE;
          end
        end
        SRC_SETTLE: begin
          if (cnt_q == '0) state_q <= SRC_VALID;
          else             cnt_q   <= cnt_q - SETTLE_W'(1);
        end
        SRC_VALID: if (pend_n_i) state_q <= SRC_IDLE;
        default: state_q <= SRC_IDLE;
      endcase
    end
  end

  assign src_ready_o = (state_q == SRC_IDLE);
  assign valid_n_o   = (state_q != SRC_VALID);
  assign data_o      = data_q;
endmodule

// File: rtl/hs_acceptor.sv
module hs_acceptor
  import hs_bus_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              valid_n_i,
  output logic              hold_n_o,
  output logic              pend_n_o,
  output logic [DATA_W-1:0] snk_data_o,
  output logic              snk_valid_o,
  input  logic              snk_ready_i
);
  acc_state_e        state_q;
  logic [DATA_W-1:0] buf_q;
  logic              full_q;
  logic              take;
  logic              hold_int_n;
  logic              pend_int_n;

  assign take = (state_q == ACC_WAIT) && en_i && !valid_n_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACC_IDLE;
      buf_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      if (take) begin
        buf_q  <= bus_data_i;
        full_q <= 1'b1;
      end else if (full_q && snk_ready_i) begin
        full_q <= 1'b0;
      end
      case (state_q)
        ACC_IDLE: if (en_i) state_q <= ACC_WAIT;
        ACC_WAIT: begin
          if (!en_i)     state_q <= ACC_IDLE;
          else if (take) state_q <= ACC_HOLD;
        end
        ACC_HOLD: state_q <= ACC_DONE;  // not-ready already low
        ACC_DONE: if (valid_n_i) state_q <= ACC_WAIT;
        default:  state_q <= ACC_IDLE;
      endcase
    end
  end

  always_comb begin
    hold_int_n = 1'b0;
    pend_int_n = 1'b0;
    case (state_q)
      ACC_WAIT: hold_int_n = !full_q;
      ACC_DONE: pend_int_n = 1'b1;
      default: ;
    endcase
  end

  // disabled listener releases both lines
  assign hold_n_o    = en_i ? hold_int_n : 1'b1;
  assign pend_n_o    = en_i ? pend_int_n : 1'b1;
  assign snk_data_o  = buf_q;
  assign snk_valid_o = full_q;
endmodule

// File: rtl/hs_bus_top.sv
module hs_bus_top #(
  parameter int unsigned N_LSN    = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SETTLE_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SETTLE_W-1:0]     settle_i,
  input  logic [DATA_W-1:0]       src_data_i,
  input  logic                    src_valid_i,
  output logic                    src_ready_o,
  input  logic [N_LSN-1:0]        lsn_en_i,
  output logic [N_LSN*DATA_W-1:0] snk_data_o,
  output logic [N_LSN-1:0]        snk_valid_o,
  input  logic [N_LSN-1:0]        snk_ready_i,
  output logic [DATA_W-1:0]       bus_data_o,
  output logic                    bus_valid_n_o,
  output logic                    bus_hold_n_o,
  output logic                    bus_pend_n_o
);
  localparam int unsigned SNK_W = N_LSN * DATA_W;

  logic [N_LSN-1:0]  hold_drv_n;
  logic [N_LSN-1:0]  pend_drv_n;
  logic [SNK_W-1:0]  snk_data;

  hs_source #(.DATA_W(DATA_W), .SETTLE_W(SETTLE_W)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .settle_i    (settle_i),
    .src_data_i  (src_data_i),
    .src_valid_i (src_valid_i),
    .src_ready_o (src_ready_o),
    .hold_n_i    (bus_hold_n_o),
    .pend_n_i    (bus_pend_n_o),
    .data_o      (bus_data_o),
    .valid_n_o   (bus_valid_n_o)
  );

  for (genvar i = 0; i < N_LSN; i++) begin : g_lsn
    hs_acceptor #(.DATA_W(DATA_W)) u_acc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (lsn_en_i[i]),
      .bus_data_i  (bus_data_o),
      .valid_n_i   (bus_valid_n_o),
      .hold_n_o    (hold_drv_n[i]),
      .pend_n_o    (pend_drv_n[i]),
      .snk_data_o  (snk_data[i*DATA_W +: DATA_W]),
      .snk_valid_o (snk_valid_o[i]),
      .snk_ready_i (snk_ready_i[i])
    );
  end

  hs_wired_line #(.N_DRV(N_LSN)) u_hold_line (
    .drive_n_i (hold_drv_n),
    .line_n_o  (bus_hold_n_o)
  );

  hs_wired_line #(.N_DRV(N_LSN)) u_pend_line (
    .drive_n_i (pend_drv_n),
    .line_n_o  (bus_pend_n_o)
  );

  assign snk_data_o = snk_data;
endmodule

// File: rtl/hs_bus_checker.sv
module hs_bus_checker #(
  parameter int unsigned N_LSN  = 3,
  parameter int unsigned DATA_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_LSN*DATA_W-1:0] snk_data_o,
  input logic [N_LSN-1:0]        snk_valid_o,
  input logic [N_LSN-1:0]        snk_ready_i,
  input logic [DATA_W-1:0]       bus_data_o,
  input logic                    bus_valid_n_o,
  input logic                    bus_hold_n_o,
  input logic                    bus_pend_n_o
);
  assert_valid_needs_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_valid_n_o) |-> (bus_hold_n_o && !bus_pend_n_o));

  assert_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_valid_n_o && !$past(bus_valid_n_o)) |-> $stable(bus_data_o));

  assert_release_after_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_valid_n_o) |-> bus_pend_n_o);

  assert_pend_rise_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_pend_n_o) |-> (!bus_hold_n_o && !bus_valid_n_o));

  for (genvar i = 0; i < N_LSN; i++) begin : g_snk
    assert_sink_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snk_valid_o[i] && !snk_ready_i[i]) |=>
        (snk_valid_o[i] && $stable(snk_data_o[i*DATA_W +: DATA_W])));
  end
endmodule

bind hs_bus_top hs_bus_checker #(.N_LSN(N_LSN), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .snk_data_o    (snk_data_o),
  .snk_valid_o   (snk_valid_o),
  .snk_ready_i   (snk_ready_i),
  .bus_data_o    (bus_data_o),
  .bus_valid_n_o (bus_valid_n_o),
  .bus_hold_n_o  (bus_hold_n_o),
  .bus_pend_n_o  (bus_pend_n_o)
);

// File: tb/hs_bus_top_bench.sv
`timescale 1ns/100ps
module hs_bus_top_bench;
  localparam int N = 3;
  localparam int W = 8;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] settle = '0;
  logic [W-1:0]  src_data = '0;
  logic          src_valid = 1'b0;
  logic          src_ready;
  logic [N-1:0]  lsn_en = '1;
  logic [N*W-1:0] snk_data;
  logic [N-1:0]  snk_valid;
  logic [N-1:0]  snk_ready = '1;
  logic [W-1:0]  bus_data;
  logic          valid_n, hold_n, pend_n;

  int checks = 0;
  int fails = 0;
  int rx_cnt [N];
  logic [W-1:0] rx_log [N][32];
  int r8_bad = 0;
  int r2_bad = 0;
  logic prev_pend = 1'b0;
  logic prev_valid = 1'b1;

  always #2.5 clk = ~clk;

  hs_bus_top #(.N_LSN(N), .DATA_W(W), .SETTLE_W(SW)) u_hs_bus_top (
    .clk_i(clk), .rst_ni(rst_n), .settle_i(settle),
    .src_data_i(src_data), .src_valid_i(src_valid), .src_ready_o(src_ready),
    .lsn_en_i(lsn_en), .snk_data_o(snk_data), .snk_valid_o(snk_valid),
    .snk_ready_i(snk_ready), .bus_data_o(bus_data), .bus_valid_n_o(valid_n),
    .bus_hold_n_o(hold_n), .bus_pend_n_o(pend_n)
  );

  // sink logger and line-order monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (snk_valid[i] && snk_ready[i] && rx_cnt[i] < 32) begin
          rx_log[i][rx_cnt[i]] = snk_data[i*W +: W];
          rx_cnt[i]++;
        end
      end
      if (pend_n && !prev_pend && hold_n) r8_bad++;
      if (!valid_n && prev_valid && (!hold_n || pend_n)) r2_bad++;
    end
    prev_pend  = pend_n;
    prev_valid = valid_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] b);
    @(posedge clk); #1;
    src_data  = b;
    src_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (src_ready) break;
    end
    @(posedge clk); #1;
    src_valid = 1'b0;
  endtask

  task automatic wait_rx(input int i, input int n);
    for (int k = 0; k < 400; k++) begin
      if (rx_cnt[i] >= n) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(valid_n == 1'b1, "R1 valid", valid_n, 1);
    chk(hold_n == 1'b0, "R1 hold", hold_n, 0);
    chk(pend_n == 1'b0, "R1 pend", pend_n, 0);
    chk(snk_valid == '0, "R1 snk_valid", snk_valid, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic t_single();
    int base [N];
    for (int i = 0; i < N; i++) base[i] = rx_cnt[i];
    push(8'h3c);
    for (int i = 0; i < N; i++) wait_rx(i, base[i] + 1);
    for (int i = 0; i < N; i++)
      chk(rx_log[i][base[i]] == 8'h3c, "R5 single byte", rx_log[i][base[i]], 8'h3c);
    repeat (4) @(negedge clk);
    chk(pend_n == 1'b0, "R8 pend reasserted", pend_n, 0);
    chk(valid_n == 1'b1 && hold_n == 1'b1, "R8 idle lines", {valid_n, hold_n}, 2'b11);
  endtask

  task automatic t_burst();
    logic [W-1:0] pat [5] = '{8'h00, 8'hff, 8'ha5, 8'h5a, 8'h81};
    int base [N];
    for (int i = 0; i < N; i++) base[i] = rx_cnt[i];
    for (int k = 0; k < 5; k++) push(pat[k]);
    for (int i = 0; i < N; i++) wait_rx(i, base[i] + 5);
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 5; k++)
        chk(rx_log[i][base[i]+k] == pat[k], "R5 burst order", rx_log[i][base[i]+k], pat[k]);
  endtask

  task automatic t_stall();
    int base [N];
    for (int i = 0; i < N; i++) base[i] = rx_cnt[i];
    @(posedge clk); #1;
    snk_ready = 3'b110;
    push(8'h11);
    wait_rx(1, base[1] + 1);
    wait_rx(2, base[2] + 1);
    push(8'h22);
    repeat (30) @(negedge clk);
    chk(rx_cnt[1] == base[1] + 1, "R7 others stalled", rx_cnt[1], base[1] + 1);
    chk(valid_n == 1'b1, "R2 no valid while held", valid_n, 1);
    chk(hold_n == 1'b0, "R7 hold line low", hold_n, 0);
    chk(src_ready == 1'b0, "R9 talker busy", src_ready, 0);
    chk(snk_valid[0] && snk_data[W-1:0] == 8'h11, "R5 sink holds byte", snk_data[W-1:0], 8'h11);
    @(posedge clk); #1;
    snk_ready = 3'b111;
    for (int i = 0; i < N; i++) wait_rx(i, base[i] + 2);
    chk(rx_log[0][base[0]] == 8'h11, "R7 first byte kept", rx_log[0][base[0]], 8'h11);
    chk(rx_log[0][base[0]+1] == 8'h22, "R7 second byte kept", rx_log[0][base[0]+1], 8'h22);
    chk(rx_log[2][base[2]+1] == 8'h22, "R7 others get second", rx_log[2][base[2]+1], 8'h22);
  endtask

  task automatic t_settle(input int s);
    int base [N];
    int n;
    for (int i = 0; i < N; i++) base[i] = rx_cnt[i];
    @(posedge clk); #1;
    settle    = SW'(s);
    snk_ready = 3'b110;
    push(8'h40 + 8'(s));
    wait_rx(1, base[1] + 1);
    push(8'h60 + 8'(s));
    repeat (5) @(negedge clk);
    @(posedge clk); #1;
    snk_ready = 3'b111;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (hold_n) break;
    end
    n = 0;
    while (valid_n && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(n == s + 1, "R3 settle delay", n, s + 1);
    for (int i = 0; i < N; i++) wait_rx(i, base[i] + 2);
    chk(rx_log[0][base[0]+1] == 8'h60 + 8'(s), "R3 byte after settle",
        rx_log[0][base[0]+1], 8'h60 + 8'(s));
  endtask

  task automatic t_disabled();
    int base [N];
    for (int i = 0; i < N; i++) base[i] = rx_cnt[i];
    @(posedge clk); #1;
    lsn_en    = 3'b011;
    snk_ready = 3'b011;
    push(8'hc3);
    wait_rx(0, base[0] + 1);
    wait_rx(1, base[1] + 1);
    repeat (10) @(negedge clk);
    chk(rx_cnt[0] == base[0] + 1, "R6 enabled listener got byte", rx_cnt[0], base[0] + 1);
    chk(rx_cnt[2] == base[2], "R6 disabled listener ignored", rx_cnt[2], base[2]);
    chk(snk_valid[2] == 1'b0, "R6 disabled sink empty", snk_valid[2], 0);
    chk(src_ready == 1'b1, "R6 no stall from disabled", src_ready, 1);
    @(posedge clk); #1;
    lsn_en    = 3'b111;
    snk_ready = 3'b111;
    push(8'h5c);
    for (int i = 0; i < N; i++) wait_rx(i, base[i] + (i == 2 ? 1 : 2));
    chk(rx_log[2][base[2]] == 8'h5c, "R6 re-enabled listener", rx_log[2][base[2]], 8'h5c);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < N; i++) rx_cnt[i] = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_stall();
    t_settle(0);
    t_settle(3);
    t_disabled();
    chk(r8_bad == 0, "R8 pend rose while hold released", r8_bad, 0);
    chk(r2_bad == 0, "R2 valid without ready", r2_bad, 0);
    summary();
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end
endmodule